// File: doc/BRIEF.md
# Multimode Serial Receiver with Error Flags

This block turns a serial input line into bytes. It works in three modes. Plain asynchronous mode takes frames of 7 or 8 data bits, with optional odd or even parity. Multiprocessor asynchronous mode takes frames of 8 data bits followed by one bit that marks the frame as an address or as data. Clock-synchronous mode shifts in 8 bits on the rising edges of an external shift clock. The asynchronous modes run from a one-cycle tick supplied at 16 times the bit rate. Baud generation, interrupts and register decoding are outside the block.

Each finished frame goes into a receive data register and raises a data-ready flag. Three sticky error flags record parity, overrun and framing errors. Software clears them all at once by writing zero to an error-clear control bit. That bit always reads back as one. Receive enable gates only the start of a frame: a frame already in progress always completes and is stored.

Top module: `mmode_serial_rx`

## Requirements
- R1: After reset, rx_data is 0, data_ready is 0, all three error flags are 0, and err_clr_rb reads 1.
- R2: In the asynchronous modes (cfg_mode 0 = plain, 1 = multiprocessor), a falling edge on rx_in seen at a tick opens a start bit. The line is checked again 8 ticks later, and a high level there drops the frame as noise without setting any flag.
- R3: Each later asynchronous bit is sampled 16 ticks after the previous one, least significant bit first. The completed byte appears on rx_data with data_ready set.
- R4: cfg_len7 = 1 gives 7 data bits (rx_data bit 7 reads 0), but only in plain asynchronous mode. Multiprocessor and synchronous modes always take 8 bits, whatever cfg_len7 is.
- R5: With cfg_par_en = 1 in plain mode, one parity bit follows the data. Even sense (cfg_par_odd = 0) needs an even count of ones across data and parity, and odd sense needs an odd count. A mismatch sets err_parity. The other modes never set err_parity.
- R6: In multiprocessor mode, the bit after the 8 data bits is stored in rx_addr_flag (1 = address frame). In the other modes rx_addr_flag is stored as 0.
- R7: Only the first stop bit is checked. A low level there sets err_framing. A start bit that follows the first stop bit at once, where a second stop bit would be, is still received.
- R8: When a frame completes while data_ready is still 1, err_overrun is set and rx_data keeps its old value.
- R9: A pulse on rd_strobe clears data_ready and leaves all error flags unchanged.
- R10: A ctl_wr with ctl_err_clr_n = 0 clears all three error flags together. With ctl_err_clr_n = 1 the write changes nothing. err_clr_rb is always 1.
- R11: Clearing rx_enable in the middle of a frame still lets that frame finish and be stored. No new frame starts while rx_enable is 0.
- R12: In synchronous mode (cfg_mode 2), rx_in is sampled on each rising edge of sclk_in, least significant bit first. data_ready is set after 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Serial data line |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| sclk_in | input | 1 | Shift clock for synchronous mode |
| cfg_mode | input | 2 | 0 plain async, 1 multiprocessor async, 2 synchronous |
| cfg_len7 | input | 1 | 7-bit data in plain async mode |
| cfg_par_en | input | 1 | Parity bit present (plain async only) |
| cfg_par_odd | input | 1 | 1 odd parity, 0 even parity |
| rx_enable | input | 1 | Allows new frames to start |
| rd_strobe | input | 1 | Receive data read, clears data_ready |
| ctl_wr | input | 1 | Control write strobe |
| ctl_err_clr_n | input | 1 | Written error-clear bit, 0 clears flags |
| err_clr_rb | output | 1 | Read-back of the error-clear bit, always 1 |
| rx_data | output | 8 | Receive data register |
| rx_addr_flag | output | 1 | Stored address/data marker |
| data_ready | output | 1 | New data waiting |
| err_parity | output | 1 | Sticky parity error |
| err_overrun | output | 1 | Sticky overrun error |
| err_framing | output | 1 | Sticky framing error |

## Verification
A wrong bit counter or tick counter shows up at the end of the frame. The byte on rx_data comes out shifted, or data_ready rises one bit time early or late. A noise start that is wrongly accepted produces a spurious data_ready about ten bit times after the glitch. A wrong latched mode or length shows on the next stored frame, as a parity error or an address flag that should not be there, or as a top bit that should be 0. A fault in the status register shows within one cycle of the read, clear or completion pulse that drives it.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        MODE_ASYNC = 2'd0,
        MODE_MPROC = 2'd1,
        MODE_SYNC  = 2'd2
    } srx_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_EXTRA,
        ST_STOP
    } srx_state_e;

    typedef struct packed {
        srx_mode_e mode;
        logic      len7;
        logic      par_en;
        logic      par_odd;
    } srx_cfg_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              addr;
        logic              perr;
        logic              ferr;
    } srx_frame_t;

    // number of data bits a frame carries under a configuration
    function automatic logic [3:0] frame_bits(input srx_cfg_t c);
        return (c.mode == MODE_ASYNC && c.len7) ? 4'd7 : 4'd8;
    endfunction

    // the bit after the data is present in multiprocessor mode or with parity
    function automatic logic has_extra(input srx_cfg_t c);
        return (c.mode == MODE_MPROC) || (c.mode == MODE_ASYNC && c.par_en);
    endfunction

    // data shifted in from the top, right-justify for short frames
    function automatic logic [DATA_W-1:0] align_data(input logic [DATA_W-1:0] sh,
                                                     input logic short_len);
        return short_len ? {1'b0, sh[DATA_W-1:1]} : sh;
    endfunction

    function automatic logic parity_bad(input logic [DATA_W-1:0] d,
                                        input logic pbit, input logic odd);
        return ((^d) ^ pbit) != odd;
    endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
            prev  <= RST_VAL;
        end else begin
            chain <= {chain[STAGES-2:0], d};
            prev  <= chain[STAGES-1];
        end
    end

    assign q    = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/srx_frame_engine.sv
module srx_frame_engine
    import srx_pkg::*;
#(
    parameter int OS_RATE = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_s,
    input  logic       os_tick,
    input  logic       sclk_rise,
    input  srx_cfg_t   cfg,
    input  logic       enable,
    output logic       done,
    output srx_frame_t frame
);
    localparam int CW = $clog2(OS_RATE);
    localparam logic [CW-1:0] CNT_HALF = CW'(OS_RATE / 2 - 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(OS_RATE - 1);

    srx_state_e        state;
    srx_cfg_t          cfg_q;
    logic [CW-1:0]     cnt;
    logic [3:0]        bitn;
    logic [DATA_W-1:0] shreg;
    logic              extra_q;
    logic              rx_prev;

    logic              is_sync;
    logic              sample_now;
    logic [DATA_W-1:0] sh_next;

    assign is_sync    = (cfg_q.mode == MODE_SYNC);
    assign sample_now = is_sync ? sclk_rise : (os_tick && cnt == CNT_LAST);
    assign sh_next    = {rx_s, shreg[DATA_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cfg_q   <= '0;
            cnt     <= '0;
            bitn    <= '0;
            shreg   <= '0;
            extra_q <= 1'b0;
            rx_prev <= 1'b1;
            done    <= 1'b0;
            frame   <= '0;
        end else begin
            done <= 1'b0;
            if (os_tick) rx_prev <= rx_s;

            // tick counter runs inside asynchronous frames only
            if (state != ST_IDLE && !is_sync && os_tick)
                cnt <= (cnt == CNT_LAST) ? '0 : cnt + 1'b1;

            unique case (state)
                ST_IDLE: begin
                    if (enable) begin
                        if (cfg.mode == MODE_SYNC) begin
                            if (sclk_rise) begin
                                cfg_q <= cfg;
                                shreg <= sh_next;
                                bitn  <= 4'd1;
                                state <= ST_DATA;
                            end
                        end else if (os_tick && rx_prev && !rx_s) begin
                            cfg_q <= cfg;
                            cnt   <= '0;
                            state <= ST_START;
                        end
                    end
                end
                ST_START: begin
                    if (os_tick && cnt == CNT_HALF) begin
                        cnt <= '0;
                        if (rx_s) begin
                            state <= ST_IDLE;
                        end else begin
                            bitn  <= '0;
                            state <= ST_DATA;
                        end
                    end
                end
                ST_DATA: begin
                    if (sample_now) begin
                        shreg <= sh_next;
                        bitn  <= bitn + 1'b1;
                        if (bitn + 1'b1 == frame_bits(cfg_q)) begin
                            if (is_sync) begin
                                done        <= 1'b1;
                                frame.data  <= sh_next;
                                frame.addr  <= 1'b0;
                                frame.perr  <= 1'b0;
                                frame.ferr  <= 1'b0;
                                state       <= ST_IDLE;
                            end else begin
                                state <= has_extra(cfg_q) ? ST_EXTRA : ST_STOP;
                            end
                        end
                    end
                end
                ST_EXTRA: begin
                    if (sample_now) begin
                        extra_q <= rx_s;
                        state   <= ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (sample_now) begin
                        done       <= 1'b1;
                        frame.data <= align_data(shreg, frame_bits(cfg_q) == 4'd7);
                        frame.addr <= (cfg_q.mode == MODE_MPROC) && extra_q;
                        frame.perr <= (cfg_q.mode == MODE_ASYNC) && cfg_q.par_en &&
                                      parity_bad(align_data(shreg, frame_bits(cfg_q) == 4'd7),
                                                 extra_q, cfg_q.par_odd);
                        frame.ferr <= !rx_s;
                        state      <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/srx_status.sv
module srx_status
    import srx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  srx_frame_t        frame,
    input  logic              rd_strobe,
    input  logic              ctl_wr,
    input  logic              ctl_err_clr_n,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_addr_flag,
    output logic              data_ready,
    output logic              err_parity,
    output logic              err_overrun,
    output logic              err_framing
);
    logic clr_req;
    assign clr_req = ctl_wr && !ctl_err_clr_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data      <= '0;
            rx_addr_flag <= 1'b0;
            data_ready   <= 1'b0;
            err_parity   <= 1'b0;
            err_overrun  <= 1'b0;
            err_framing  <= 1'b0;
        end else begin
            if (clr_req) begin
                err_parity  <= 1'b0;
                err_overrun <= 1'b0;
                err_framing <= 1'b0;
            end
            if (rd_strobe) data_ready <= 1'b0;
            if (done) begin
                if (data_ready && !rd_strobe) begin
                    err_overrun <= 1'b1;
                end else begin
                    rx_data      <= frame.data;
                    rx_addr_flag <= frame.addr;
                    data_ready   <= 1'b1;
                    if (frame.perr) err_parity  <= 1'b1;
                    if (frame.ferr) err_framing <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mmode_serial_rx.sv
module mmode_serial_rx
    import srx_pkg::*;
#(
    parameter int OS_RATE     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_in,
    input  logic       os_tick,
    input  logic       sclk_in,
    input  logic [1:0] cfg_mode,
    input  logic       cfg_len7,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       rx_enable,
    input  logic       rd_strobe,
    input  logic       ctl_wr,
    input  logic       ctl_err_clr_n,
    output logic       err_clr_rb,
    output logic [7:0] rx_data,
    output logic       rx_addr_flag,
    output logic       data_ready,
    output logic       err_parity,
    output logic       err_overrun,
    output logic       err_framing
);
    logic       rx_s;
    logic       rx_rise_unused;
    logic       sclk_s_unused;
    logic       sclk_rise;
    srx_cfg_t   cfg;
    logic       fr_done;
    srx_frame_t fr;

    assign cfg.mode    = srx_mode_e'(cfg_mode);
    assign cfg.len7    = cfg_len7;
    assign cfg.par_en  = cfg_par_en;
    assign cfg.par_odd = cfg_par_odd;
    assign err_clr_rb  = 1'b1;

    srx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rx_sync (
        .clk(clk), .rst(rst), .d(rx_in), .q(rx_s), .rise(rx_rise_unused)
    );

    srx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sclk_sync (
        .clk(clk), .rst(rst), .d(sclk_in), .q(sclk_s_unused), .rise(sclk_rise)
    );

    srx_frame_engine #(.OS_RATE(OS_RATE)) u_eng (
        .clk(clk), .rst(rst), .rx_s(rx_s), .os_tick(os_tick),
        .sclk_rise(sclk_rise), .cfg(cfg), .enable(rx_enable),
        .done(fr_done), .frame(fr)
    );

    srx_status u_stat (
        .clk(clk), .rst(rst), .done(fr_done), .frame(fr),
        .rd_strobe(rd_strobe), .ctl_wr(ctl_wr), .ctl_err_clr_n(ctl_err_clr_n),
        .rx_data(rx_data), .rx_addr_flag(rx_addr_flag), .data_ready(data_ready),
        .err_parity(err_parity), .err_overrun(err_overrun), .err_framing(err_framing)
    );
endmodule

// File: rtl/srx_checker.sv
module srx_checker (
    input logic       clk,
    input logic       rst,
    input logic       rd_strobe,
    input logic       ctl_wr,
    input logic       ctl_err_clr_n,
    input logic       fr_done,
    input logic       fr_ferr,
    input logic [7:0] rx_data,
    input logic       data_ready,
    input logic       err_parity,
    input logic       err_overrun,
    input logic       err_framing
);
    // R3: a completed frame with no pending data raises data_ready
    p_ready_on_done_r3: assert property (@(posedge clk) disable iff (rst)
        fr_done && !data_ready |=> data_ready);

    // R7: a low first stop bit reaches the framing flag
    p_framing_set_r7: assert property (@(posedge clk) disable iff (rst)
        fr_done && !data_ready && fr_ferr |=> err_framing);

    // R8: an overrun leaves the stored byte untouched
    p_overrun_keeps_data_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(err_overrun) |-> $stable(rx_data));

    // R9: a read with no completion in the same cycle empties the register
    p_read_clears_ready_r9: assert property (@(posedge clk) disable iff (rst)
        rd_strobe && !fr_done |=> !data_ready);

    // R9: a read alone never touches the error flags
    p_read_keeps_flags_r9: assert property (@(posedge clk) disable iff (rst)
        rd_strobe && !ctl_wr && !fr_done |=>
        $stable(err_parity) && $stable(err_overrun) && $stable(err_framing));

    // R10: a zero write to the clear bit drops all flags
    p_clear_flags_r10: assert property (@(posedge clk) disable iff (rst)
        ctl_wr && !ctl_err_clr_n && !fr_done |=>
        !err_parity && !err_overrun && !err_framing);
endmodule

bind mmode_serial_rx srx_checker u_chk (
    .clk(clk), .rst(rst), .rd_strobe(rd_strobe), .ctl_wr(ctl_wr),
    .ctl_err_clr_n(ctl_err_clr_n), .fr_done(fr_done), .fr_ferr(fr.ferr),
    .rx_data(rx_data), .data_ready(data_ready), .err_parity(err_parity),
    .err_overrun(err_overrun), .err_framing(err_framing)
);

// File: tb/mmode_serial_rx_test.sv
`timescale 1ns/1ps
module mmode_serial_rx_test;
    localparam int BIT_CLKS = 64; // 16 ticks of 4 clocks

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_in = 1'b1, os_tick = 1'b0, sclk_in = 1'b1;
    logic [1:0] cfg_mode = 2'd0;
    logic cfg_len7 = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic rx_enable = 1'b1, rd_strobe = 1'b0, ctl_wr = 1'b0, ctl_err_clr_n = 1'b1;
    logic err_clr_rb, rx_addr_flag, data_ready, err_parity, err_overrun, err_framing;
    logic [7:0] rx_data;
    int checks = 0, errors = 0;
    logic [1:0] tcnt = 2'd0;

    always #10 clk = ~clk;

    always @(negedge clk) begin
        tcnt    <= tcnt + 2'd1;
        os_tick <= (tcnt == 2'd3);
    end

    mmode_serial_rx uut (
        .clk(clk), .rst(rst), .rx_in(rx_in), .os_tick(os_tick), .sclk_in(sclk_in),
        .cfg_mode(cfg_mode), .cfg_len7(cfg_len7), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .rx_enable(rx_enable), .rd_strobe(rd_strobe),
        .ctl_wr(ctl_wr), .ctl_err_clr_n(ctl_err_clr_n), .err_clr_rb(err_clr_rb),
        .rx_data(rx_data), .rx_addr_flag(rx_addr_flag), .data_ready(data_ready),
        .err_parity(err_parity), .err_overrun(err_overrun), .err_framing(err_framing)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic good_parity(input logic [7:0] d, input int nb, input logic odd);
        logic x = 1'b0;
        for (int i = 0; i < nb; i++) x ^= d[i];
        return x ^ odd;
    endfunction

    task automatic send_bit(input logic b);
        rx_in = b;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic send_async(input logic [7:0] d, input int nb, input bit ext,
                              input logic ext_bit, input logic stop, input int idle);
        send_bit(1'b0);
        for (int i = 0; i < nb; i++) send_bit(d[i]);
        if (ext) send_bit(ext_bit);
        send_bit(stop);
        rx_in = 1'b1;
        repeat (idle) @(negedge clk);
    endtask

    task automatic send_sync(input logic [7:0] d);
        for (int i = 0; i < 8; i++) begin
            sclk_in = 1'b0;
            rx_in   = d[i];
            repeat (8) @(negedge clk);
            sclk_in = 1'b1;
            repeat (8) @(negedge clk);
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic do_read();
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic ctl_write(input logic v);
        ctl_wr = 1'b1;
        ctl_err_clr_n = v;
        @(negedge clk);
        ctl_wr = 1'b0;
        ctl_err_clr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (40) @(negedge clk);

        // R1 reset state
        check("R1 ready", data_ready, 0);
        check("R1 data", rx_data, 0);
        check("R1 flags", {err_parity, err_overrun, err_framing}, 0);
        check("R1 readback", err_clr_rb, 1);

        // R3 plain 8-bit frame
        send_async(8'hA5, 8, 0, 0, 1, 40);
        check("R3 data A5", rx_data, 8'hA5);
        check("R3 ready", data_ready, 1);
        check("R3 no errors", {err_parity, err_overrun, err_framing}, 0);

        // R9 read clears ready
        do_read();
        check("R9 ready cleared", data_ready, 0);

        // R2 short low glitch rejected
        rx_in = 1'b0;
        repeat (12) @(negedge clk);
        rx_in = 1'b1;
        repeat (BIT_CLKS * 12) @(negedge clk);
        check("R2 glitch no ready", data_ready, 0);
        check("R2 glitch no flags", {err_parity, err_overrun, err_framing}, 0);
        send_async(8'h3C, 8, 0, 0, 1, 40);
        check("R2 frame after glitch", rx_data, 8'h3C);
        do_read();

        // R4 7-bit plain mode
        cfg_len7 = 1'b1;
        send_async(8'h55, 7, 0, 0, 1, 40);
        check("R4 seven bit data", rx_data, 8'h55);
        do_read();
        send_async(8'h7F, 7, 0, 0, 1, 40);
        check("R4 seven bit top zero", rx_data, 8'h7F);
        do_read();
        cfg_len7 = 1'b0;

        // R5 parity even good, even bad, odd good
        cfg_par_en = 1'b1;
        send_async(8'h0F, 8, 1, good_parity(8'h0F, 8, 0), 1, 40);
        check("R5 even good", err_parity, 0);
        do_read();
        send_async(8'h0E, 8, 1, ~good_parity(8'h0E, 8, 0), 1, 40);
        check("R5 even bad", err_parity, 1);
        check("R5 bad data stored", rx_data, 8'h0E);
        do_read();
        // R10 write one leaves flags
        ctl_write(1'b1);
        check("R10 write one no effect", err_parity, 1);
        check("R10 readback one", err_clr_rb, 1);
        ctl_write(1'b0);
        check("R10 write zero clears", {err_parity, err_overrun, err_framing}, 0);
        cfg_par_odd = 1'b1;
        send_async(8'h81, 8, 1, good_parity(8'h81, 8, 1), 1, 40);
        check("R5 odd good", err_parity, 0);
        do_read();
        send_async(8'h81, 8, 1, ~good_parity(8'h81, 8, 1), 1, 40);
        check("R5 odd bad", err_parity, 1);
        do_read();
        ctl_write(1'b0);
        cfg_par_en = 1'b0;
        cfg_par_odd = 1'b0;

        // R7 framing error, R9 read leaves it
        send_async(8'h42, 8, 0, 0, 0, 40);
        check("R7 framing set", err_framing, 1);
        check("R7 data still stored", rx_data, 8'h42);
        do_read();
        check("R9 read keeps framing", err_framing, 1);
        check("R9 read ready low", data_ready, 0);
        ctl_write(1'b0);
        check("R10 framing cleared", err_framing, 0);

        // R8 overrun and R7 single stop: back-to-back frames, no read
        send_async(8'h11, 8, 0, 0, 1, 0);
        send_async(8'h22, 8, 0, 0, 1, 40);
        check("R8 overrun set", err_overrun, 1);
        check("R8 old data kept", rx_data, 8'h11);
        check("R7 no framing on tight start", err_framing, 0);
        do_read();
        ctl_write(1'b0);
        check("R10 overrun cleared", err_overrun, 0);

        // R6 multiprocessor, R4 len7 ignored, R5 parity never checked
        cfg_mode = 2'd1;
        cfg_len7 = 1'b1;
        cfg_par_en = 1'b1;
        send_async(8'hC3, 8, 1, 1, 1, 40);
        check("R6 address flag", rx_addr_flag, 1);
        check("R4 mproc eight bits", rx_data, 8'hC3);
        check("R5 no parity in mproc", err_parity, 0);
        do_read();
        send_async(8'h01, 8, 1, 0, 1, 40);
        check("R6 data flag", rx_addr_flag, 0);
        check("R5 no parity in mproc b", err_parity, 0);
        do_read();

        // R12 synchronous, R4 len7 ignored
        cfg_mode = 2'd2;
        send_sync(8'h96);
        check("R12 sync data", rx_data, 8'h96);
        check("R12 sync ready", data_ready, 1);
        check("R6 sync addr zero", rx_addr_flag, 0);
        check("R5 no parity in sync", err_parity, 0);
        do_read();
        send_sync(8'h6B);
        check("R12 sync second", rx_data, 8'h6B);
        do_read();
        cfg_mode = 2'd0;
        cfg_len7 = 1'b0;
        cfg_par_en = 1'b0;
        rx_in = 1'b1;
        repeat (BIT_CLKS) @(negedge clk);

        // R11 disable mid-frame
        fork
            send_async(8'hE7, 8, 0, 0, 1, 40);
            begin
                repeat (BIT_CLKS * 3) @(negedge clk);
                rx_enable = 1'b0;
            end
        join
        check("R11 frame finished", rx_data, 8'hE7);
        check("R11 ready", data_ready, 1);
        do_read();
        send_async(8'h5A, 8, 0, 0, 1, 40);
        check("R11 disabled no frame", data_ready, 0);
        check("R11 data unchanged", rx_data, 8'hE7);
        rx_enable = 1'b1;
        repeat (BIT_CLKS) @(negedge clk);

        // R3 R5 random plain frames
        for (int n = 0; n < 24; n++) begin
            logic [7:0] d;
            logic pe, od, bad, l7;
            int nb;
            d  = 8'($urandom);
            pe = 1'($urandom);
            od = 1'($urandom);
            bad = ($urandom % 4) == 0;
            l7 = ($urandom % 3) == 0;
            nb = l7 ? 7 : 8;
            if (l7) d[7] = 1'b0;
            cfg_len7 = l7;
            cfg_par_en = pe;
            cfg_par_odd = od;
            send_async(d, nb, pe, good_parity(d, nb, od) ^ bad, 1, 40);
            check("R3 random data", rx_data, d);
            check("R5 random parity", err_parity, pe & bad);
            do_read();
            ctl_write(1'b0);
        end

        finish_run();
    end
endmodule